// File: doc/BRIEF.md
# Dead-Band PWM Generator

This block produces a pair of pulse-width modulated signals from one 16-bit counter. The counter runs in one of two shapes: a falling ramp that restarts from the period value, which gives edge-aligned waveforms, or a triangle that climbs from zero to the period value and falls back, which gives center-aligned waveforms. Four counter events are recognised: the count at zero, the count at the period value, and the count equal to either of two compare values. Each of the two signals is driven by a small table of per-event actions that can set, clear or toggle the signal, so each edge of the waveform is placed by choosing which event drives it.

The period and compare values can either follow their inputs at once or be held until the counter next sits at zero, so that software can rewrite them mid-period without a torn cycle. An optional dead-band stage turns the first signal into a complementary pair with a programmable delay on each rising edge. The final stage enables, inverts and, on a fault or stall request, forces both pins to a programmed safe level. Registered pulses report each counter event.

Top module: `pwm_gen`

## Requirements
- R1: With `updown`=0 the counter falls by one per clock and, on the clock after it reads zero, reloads `load_val`; the period is `load_val`+1 clocks.
- R2: With `updown`=1 the counter steps 0,1,…,L,L-1,…,1,0 and repeats, a period of 2L clocks for an active period value L>0; with L=0 it stays at zero.
- R3: `ev_zero`, `ev_load`, `ev_cmpa`, `ev_cmpb` are high for exactly the clock after the counter equals zero, the active period value, the active compare A value and the active compare B value respectively.
- R4: Each 2-bit action code means 00 keep, 01 toggle, 10 drive low, 11 drive high; in each 12-bit action word bits [1:0] act on zero, [3:2] on period, [5:4] on compare A while rising, [7:6] on compare A while falling, [9:8] on compare B while rising, [11:10] on compare B while falling. Raw signals start low after reset.
- R5: When events coincide only the highest-priority one present acts, in the order compare B, compare A, period, zero, even if its code is 00.
- R6: The rising-slope compare fields apply only in `updown`=1 while the counter climbs (including the count equal to the period value); at all other times the falling-slope fields apply.
- R7: With `defer_upd`=1 the active period and compare values take the inputs only on a clock where the counter reads zero; with `defer_upd`=0 they take them every clock.
- R8: With `db_en`=1 the true output goes high `db_rise` clocks later than the first raw signal and falls with it; the complement is the inverse of the first raw signal, going high `db_fall` clocks late; the two are never high together.
- R9: With `db_en`=0 the two raw signals pass through the dead-band stage unchanged.
- R10: Output bit i is low when `out_en`[i]=0, else the dead-band output i XOR `out_inv`[i] (bit 0 is `pwm_a`, bit 1 is `pwm_b`).
- R11: While `fault_in` or `stall_in` is high the pins take `safe_val` one clock later, overriding enable and inversion.
- R12: A high `sync_in` restarts the counter at zero on a rising slope on the next clock.
- R13: During reset both pins and all event pulses are low and the counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| updown | input | 1 | 0 falling ramp, 1 triangle |
| defer_upd | input | 1 | 1 holds new period and compare values until zero |
| sync_in | input | 1 | Counter restart strobe |
| load_val | input | 16 | Period value |
| cmpa_val | input | 16 | Compare A value |
| cmpb_val | input | 16 | Compare B value |
| act_cfg_a | input | 12 | Action word for the first signal |
| act_cfg_b | input | 12 | Action word for the second signal |
| db_en | input | 1 | Dead-band stage enable |
| db_rise | input | 12 | Rising-edge delay of the true output, clocks |
| db_fall | input | 12 | Rising-edge delay of the complement, clocks |
| out_en | input | 2 | Per-pin enable |
| out_inv | input | 2 | Per-pin inversion |
| fault_in | input | 1 | External fault request |
| stall_in | input | 1 | Stall request |
| safe_val | input | 2 | Pin levels forced on fault or stall |
| pwm_a | output | 1 | First PWM pin |
| pwm_b | output | 1 | Second PWM pin |
| ev_zero | output | 1 | Counter-at-zero pulse |
| ev_load | output | 1 | Counter-at-period pulse |
| ev_cmpa | output | 1 | Compare A match pulse |
| ev_cmpb | output | 1 | Compare B match pulse |

## Verification
The hardest condition to reach from the pins is several events landing on the same count while a deferred update is pending, since it needs compare values equal to zero or to the period and a rewrite in the middle of a period. The bench sets compare A and B to zero and to the period value to force two- and three-way coincidences, and rewrites the period and compare inputs a few clocks after a reload in both update modes, comparing every clock against a cycle model of the requirements. Dead-band delays are swept past the raw pulse width so that a pulse shorter than its delay is swallowed.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  typedef struct packed {
    logic cmpb;
    logic cmpa;
    logic load;
    logic zero;
  } events_t;

  localparam int ACT_W = 12;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_gen_counter.sv
module pwm_gen_counter
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             updown,
  input  logic             defer_upd,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] load_in,
  input  logic [CNT_W-1:0] cmpa_in,
  input  logic [CNT_W-1:0] cmpb_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_load,
  output logic             slope_up,
  output events_t          ev
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] act_a, act_b;
  logic             up_q;
  logic             take;

  always_comb begin
    ev.zero = (cnt == '0);
    ev.load = (cnt == act_load);
    ev.cmpa = (cnt == act_a);
    ev.cmpb = (cnt == act_b);
  end

  assign slope_up = updown & up_q;
  assign take     = ~defer_upd | ev.zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      up_q     <= 1'b1;
      act_load <= '0;
      act_a    <= '0;
      act_b    <= '0;
    end else begin
      if (take) begin
        act_load <= load_in;
        act_a    <= cmpa_in;
        act_b    <= cmpb_in;
      end
      if (sync_in) begin
        cnt  <= '0;
        up_q <= 1'b1;
      end else if (!updown) begin
        cnt <= ev.zero ? load_in : cnt - ONE;
      end else if (act_load == '0) begin
        cnt  <= '0;
        up_q <= 1'b1;
      end else if (up_q) begin
        if (cnt >= act_load) begin
          cnt  <= cnt - ONE;
          up_q <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (ev.zero) begin
        cnt  <= ONE;
        up_q <= 1'b1;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

endmodule

// File: rtl/pwm_gen_action.sv
module pwm_gen_action
  import pwm_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  events_t          ev,
  input  logic             slope_up,
  input  logic [ACT_W-1:0] cfg,
  output logic             sig
);
  logic [1:0] code;

  always_comb begin
    if (ev.cmpb)      code = slope_up ? cfg[9:8] : cfg[11:10];
    else if (ev.cmpa) code = slope_up ? cfg[5:4] : cfg[7:6];
    else if (ev.load) code = cfg[3:2];
    else if (ev.zero) code = cfg[1:0];
    else              code = ACT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) sig <= 1'b0;
    else     sig <= apply_act(code, sig);
  end

endmodule

// File: rtl/pwm_gen_deadband.sv
module pwm_gen_deadband #(
  parameter int DB_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            db_en,
  input  logic [DB_W-1:0] rise_dly,
  input  logic [DB_W-1:0] fall_dly,
  input  logic            in_a,
  input  logic            in_b,
  output logic            out_t,
  output logic            out_c
);
  localparam logic [DB_W-1:0] SAT = '1;
  localparam logic [DB_W-1:0] ONE = DB_W'(1);

  logic [DB_W-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      out_t  <= 1'b0;
      out_c  <= 1'b0;
    end else begin
      hi_cnt <= in_a  ? ((hi_cnt == SAT) ? SAT : hi_cnt + ONE) : '0;
      lo_cnt <= !in_a ? ((lo_cnt == SAT) ? SAT : lo_cnt + ONE) : '0;
      if (db_en) begin
        out_t <= in_a  && (hi_cnt >= rise_dly);
        out_c <= !in_a && (lo_cnt >= fall_dly);
      end else begin
        out_t <= in_a;
        out_c <= in_b;
      end
    end
  end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             updown,
  input  logic             defer_upd,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmpa_val,
  input  logic [CNT_W-1:0] cmpb_val,
  input  logic [ACT_W-1:0] act_cfg_a,
  input  logic [ACT_W-1:0] act_cfg_b,
  input  logic             db_en,
  input  logic [DB_W-1:0]  db_rise,
  input  logic [DB_W-1:0]  db_fall,
  input  logic [1:0]       out_en,
  input  logic [1:0]       out_inv,
  input  logic             fault_in,
  input  logic             stall_in,
  input  logic [1:0]       safe_val,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             ev_zero,
  output logic             ev_load,
  output logic             ev_cmpa,
  output logic             ev_cmpb
);
  localparam int NCH = 2;

  logic [CNT_W-1:0]           cnt, act_load;
  logic                       slope_up;
  events_t                    ev, ev_q;
  logic [NCH-1:0]             sig;
  logic [NCH-1:0][ACT_W-1:0]  cfgs;
  logic                       db_t, db_c;
  logic [NCH-1:0]             out_q;

  assign cfgs = {act_cfg_b, act_cfg_a};

  pwm_gen_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .updown(updown), .defer_upd(defer_upd),
    .sync_in(sync_in), .load_in(load_val), .cmpa_in(cmpa_val),
    .cmpb_in(cmpb_val), .cnt(cnt), .act_load(act_load),
    .slope_up(slope_up), .ev(ev)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_gen_action act_i (
      .clk(clk), .rst(rst), .ev(ev), .slope_up(slope_up),
      .cfg(cfgs[i]), .sig(sig[i])
    );
  end

  pwm_gen_deadband #(.DB_W(DB_W)) db_i (
    .clk(clk), .rst(rst), .db_en(db_en), .rise_dly(db_rise),
    .fall_dly(db_fall), .in_a(sig[0]), .in_b(sig[1]),
    .out_t(db_t), .out_c(db_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      ev_q  <= '0;
    end else begin
      ev_q <= ev;
      if (fault_in || stall_in) out_q <= safe_val;
      else                      out_q <= out_en & ({db_c, db_t} ^ out_inv);
    end
  end

  assign pwm_a   = out_q[0];
  assign pwm_b   = out_q[1];
  assign ev_zero = ev_q.zero;
  assign ev_load = ev_q.load;
  assign ev_cmpa = ev_q.cmpa;
  assign ev_cmpb = ev_q.cmpb;

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             db_en,
  input logic             defer_upd,
  input logic             fault_in,
  input logic             stall_in,
  input logic [1:0]       safe_val,
  input logic [1:0]       out_en,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_load,
  input logic             raw_a,
  input logic             db_t,
  input logic             db_c
);

  AST_DB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $past(db_en) |-> !(db_t && db_c)); // R8

  AST_DB_RISE_AFTER_RAW: assert property (@(posedge clk) disable iff (rst)
    ($rose(db_t) && $past(db_en)) |-> $past(raw_a)); // R8

  AST_FAULT_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fault_in || stall_in)) |-> ({pwm_b, pwm_a} == $past(safe_val))); // R11

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fault_in || stall_in) && !$past(out_en[0])) |-> !pwm_a); // R10

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(defer_upd) && ($past(cnt) != '0)) |-> $stable(act_load)); // R7

endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .db_en(db_en), .defer_upd(defer_upd),
  .fault_in(fault_in), .stall_in(stall_in), .safe_val(safe_val),
  .out_en(out_en), .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt(cnt),
  .act_load(act_load), .raw_a(sig[0]), .db_t(db_t), .db_c(db_c)
);

// File: tb/pwm_gen_tb_top.sv
module pwm_gen_tb_top;
  localparam int W = 16;
  localparam int D = 12;
  localparam int SATV = (1 << D) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, updown, defer_upd, sync_in, db_en, fault_in, stall_in;
  logic [W-1:0] load_val, cmpa_val, cmpb_val;
  logic [11:0] act_cfg_a, act_cfg_b;
  logic [D-1:0] db_rise, db_fall;
  logic [1:0] out_en, out_inv, safe_val;
  logic pwm_a, pwm_b, ev_zero, ev_load, ev_cmpa, ev_cmpb;

  int checks = 0;
  int failures = 0;

  pwm_gen #(.CNT_W(W), .DB_W(D)) dut_i (
    .clk(clk), .rst(rst), .updown(updown), .defer_upd(defer_upd),
    .sync_in(sync_in), .load_val(load_val), .cmpa_val(cmpa_val),
    .cmpb_val(cmpb_val), .act_cfg_a(act_cfg_a), .act_cfg_b(act_cfg_b),
    .db_en(db_en), .db_rise(db_rise), .db_fall(db_fall), .out_en(out_en),
    .out_inv(out_inv), .fault_in(fault_in), .stall_in(stall_in),
    .safe_val(safe_val), .pwm_a(pwm_a), .pwm_b(pwm_b), .ev_zero(ev_zero),
    .ev_load(ev_load), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb)
  );

  // Cycle model built from the requirements
  int m_cnt, m_la, m_ca, m_cb, m_hi, m_lo;
  bit m_up;
  logic [1:0] m_raw, m_db, m_out;
  logic [3:0] m_ev;

  function automatic logic [1:0] pick(logic [11:0] c, bit z, bit l, bit a, bit b, bit su);
    if (b) return su ? c[9:8] : c[11:10];
    if (a) return su ? c[5:4] : c[7:6];
    if (l) return c[3:2];
    if (z) return c[1:0];
    return 2'b00;
  endfunction

  function automatic logic act(logic [1:0] code, logic cur);
    case (code)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_la = 0; m_ca = 0; m_cb = 0; m_hi = 0; m_lo = 0;
      m_raw = 0; m_db = 0; m_out = 0; m_ev = 0;
    end else begin
      bit z, l, a, b, su;
      logic [1:0] nraw, ndb, nout;
      int nhi, nlo, ncnt;
      bit nup;
      z = (m_cnt == 0); l = (m_cnt == m_la); a = (m_cnt == m_ca); b = (m_cnt == m_cb);
      su = updown && m_up;
      nraw[0] = act(pick(act_cfg_a, z, l, a, b, su), m_raw[0]);
      nraw[1] = act(pick(act_cfg_b, z, l, a, b, su), m_raw[1]);
      if (db_en) begin
        ndb[0] = m_raw[0] && (m_hi >= int'(db_rise));
        ndb[1] = !m_raw[0] && (m_lo >= int'(db_fall));
      end else ndb = m_raw;
      nhi = m_raw[0] ? ((m_hi == SATV) ? SATV : m_hi + 1) : 0;
      nlo = !m_raw[0] ? ((m_lo == SATV) ? SATV : m_lo + 1) : 0;
      nout = (fault_in || stall_in) ? safe_val : (out_en & (m_db ^ out_inv));
      ncnt = m_cnt; nup = m_up;
      if (sync_in) begin ncnt = 0; nup = 1; end
      else if (!updown) ncnt = z ? int'(load_val) : m_cnt - 1;
      else if (m_la == 0) begin ncnt = 0; nup = 1; end
      else if (m_up) begin
        if (m_cnt >= m_la) begin ncnt = m_cnt - 1; nup = 0; end
        else ncnt = m_cnt + 1;
      end else if (z) begin ncnt = 1; nup = 1; end
      else ncnt = m_cnt - 1;
      if (!defer_upd || z) begin
        m_la = int'(load_val); m_ca = int'(cmpa_val); m_cb = int'(cmpb_val);
      end
      m_ev = {b, a, l, z};
      m_cnt = ncnt; m_up = nup; m_raw = nraw; m_db = ndb; m_out = nout;
      m_hi = nhi; m_lo = nlo;
    end
  end

  function automatic logic [11:0] mk(logic [1:0] z, l, au, ad, bu, bd);
    return {bd, bu, ad, au, l, z};
  endfunction

  task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: {pwm_b,pwm_a,ev_cmpb,ev_cmpa,ev_load,ev_zero} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_int(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, {pwm_b, pwm_a, ev_cmpb, ev_cmpa, ev_load, ev_zero}, {m_out, m_ev});
    end
  endtask

  task automatic period(string tag, int exp);
    int c;
    for (int i = 0; i < 300 && !ev_zero; i++) @(negedge clk);
    c = 0;
    do begin @(negedge clk); c++; end while (!ev_zero && c < 300);
    check_int(tag, c, exp);
  endtask

  task automatic restart();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic defaults();
    updown = 0; defer_upd = 1; sync_in = 0; load_val = 5; cmpa_val = 2; cmpb_val = 4;
    act_cfg_a = mk(2'b11, 0, 0, 2'b10, 0, 0);
    act_cfg_b = mk(0, 2'b11, 0, 0, 0, 2'b10);
    db_en = 0; db_rise = 0; db_fall = 0; out_en = 2'b11; out_inv = 0;
    fault_in = 0; stall_in = 0; safe_val = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    defaults();
    rst = 1'b1;
    fault_in = 1'b1; safe_val = 2'b11;
    repeat (2) @(negedge clk);
    // R13: everything low during reset, even with a fault requested
    check("R13", {pwm_b, pwm_a, ev_cmpb, ev_cmpa, ev_load, ev_zero}, 6'b0);
    defaults();

    // R1 R3: falling ramp, period sweep
    for (int L = 1; L <= 6; L++) begin
      defaults(); load_val = W'(L); cmpa_val = W'(L / 2); cmpb_val = W'(L);
      restart(); run("R1 R3", 3 * (L + 1) + 4); period("R1", L + 1);
    end

    // R2: triangle, including a zero period value
    for (int L = 0; L <= 6; L++) begin
      defaults(); updown = 1; load_val = W'(L); cmpa_val = W'(L / 2 + 1);
      act_cfg_a = mk(2'b10, 0, 2'b11, 2'b10, 0, 0);
      restart(); run("R2", 4 * L + 6);
      if (L > 0) period("R2", 2 * L);
    end

    // R4: every action code on the zero and period events
    for (int c = 0; c < 4; c++) begin
      defaults(); load_val = 3; cmpa_val = 9; cmpb_val = 9;
      act_cfg_a = mk(2'(c), 0, 0, 0, 0, 0);
      act_cfg_b = mk(2'b01, 2'(c), 0, 0, 0, 0);
      restart(); run("R4", 20);
    end

    // R5: coincident events
    defaults(); load_val = 4; cmpa_val = 0; cmpb_val = 0;
    act_cfg_a = mk(2'b11, 2'b01, 2'b10, 2'b10, 2'b01, 2'b01);
    act_cfg_b = mk(2'b11, 2'b10, 2'b01, 2'b01, 2'b00, 2'b00);
    restart(); run("R5", 16);
    cmpa_val = 4; cmpb_val = 4; run("R5", 16);
    cmpa_val = 4; cmpb_val = 2; run("R5", 16);
    updown = 1; cmpa_val = 4; cmpb_val = 0; restart(); run("R5", 24);

    // R6: separate rising and falling compare actions
    defaults(); updown = 1; load_val = 5; cmpa_val = 2; cmpb_val = 5;
    act_cfg_a = mk(0, 0, 2'b11, 2'b10, 0, 0);
    act_cfg_b = mk(0, 0, 0, 0, 2'b01, 2'b11);
    restart(); run("R6", 30);

    // R7: deferred versus immediate updates, rewritten mid-period
    for (int m = 0; m < 4; m++) begin
      defaults(); defer_upd = m[0]; updown = m[1]; load_val = 6; cmpa_val = 3;
      restart(); run("R7", 3);
      load_val = 3; cmpa_val = 1; run("R7", 20);
      load_val = 8; cmpb_val = 7; run("R7", 4);
      cmpa_val = 6; run("R7", 30);
    end

    // R8: dead-band sweep, including a delay longer than the raw pulse
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 4; f++) begin
        defaults(); db_en = 1; load_val = 7; cmpa_val = 3;
        db_rise = D'(r); db_fall = D'(f);
        restart(); run("R8", 20);
      end
    defaults(); db_en = 1; load_val = 7; cmpa_val = 5; db_rise = 5; db_fall = 9;
    restart(); run("R8", 24);

    // R9: bypass keeps both raw signals
    defaults(); db_rise = 3; db_fall = 2; load_val = 6; cmpa_val = 1; cmpb_val = 3;
    restart(); run("R9", 24);

    // R10: enable and inversion combinations
    for (int e = 0; e < 4; e++)
      for (int v = 0; v < 4; v++) begin
        defaults(); out_en = 2'(e); out_inv = 2'(v); load_val = 3;
        restart(); run("R10", 10);
      end

    // R11: fault and stall override
    defaults(); out_inv = 2'b01; load_val = 4;
    restart(); run("R11", 4);
    fault_in = 1; safe_val = 2'b10; run("R11", 6);
    fault_in = 0; run("R11", 4);
    stall_in = 1; safe_val = 2'b01; out_en = 0; run("R11", 6);
    fault_in = 1; safe_val = 2'b11; run("R11", 3);
    fault_in = 0; stall_in = 0; run("R11", 4);

    // R12: restart strobe in both counter shapes
    for (int m = 0; m < 2; m++) begin
      defaults(); updown = m[0]; load_val = 6; cmpa_val = 2;
      restart(); run("R12", 4);
      sync_in = 1; run("R12", 1);
      sync_in = 0; run("R12", 9);
      sync_in = 1; run("R12", 3);
      sync_in = 0; run("R12", 14);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule